// File: doc/BRIEF.md
# I3C Target Private-Read Admission Controller

This block sits beside the transmit path of an I3C target. It decides whether a private read aimed at the target is accepted or refused. Once a read is accepted, it watches the transmit path until the last byte of the command is sent. It looks at the pending transmit command, the fill level of the transmit FIFO and the state of the response queue. A refusal records why the read was turned away, in status bits that software clears.

After an accepted read starts, a byte counter follows the command's length. If the FIFO runs dry before the counter reaches zero, the block records an underflow, and in I3C mode it also aborts the transfer. From then on the target refuses every private transfer until the recovery sequence has run. In I3C mode that sequence is a GETSTATUS read by the controller plus a software resume, in either order. In I2C mode the transfer cannot be aborted and a resume alone is enough. A separate refill request tells a DMA engine or an interrupt handler when the FIFO has enough free space to top it up.

Top module: `i3c_rd_admit`

## Requirements
- R1: A read-address strobe while idle gives a one-cycle `ack_o` pulse on the next clock edge only if all four of these hold: a command is valid, the FIFO level is at least the command length or at least `start_thld_i`, the response queue is not full, and no underflow is pending. Otherwise it gives a one-cycle `nack_o` pulse. The two pulses are never high together.
- R2: A refusal caused by a missing command sets `sts_rdreq_o` and leaves `sts_dnr_o` unchanged.
- R3: A refusal caused by too little FIFO data, or by a full response queue while a command is present, sets `sts_dnr_o`. Such refusals repeat for as long as the data stays short.
- R4: Writing `sts_clr_i` bit 0 clears `sts_rdreq_o` and writing bit 1 clears `sts_dnr_o`. A set in the same cycle takes precedence over the clear. `sts_clr_i` never clears `sts_uflow_o`.
- R5: An accept loads the byte counter with the command length and raises `busy_o`. Each pop while busy counts down by one. The pop that sends the last byte gives a one-cycle `done_o` pulse and drops `busy_o`.
- R6: In I3C mode (`i2c_mode_i`=0), a pop while busy with the FIFO level at 0 sets `sts_uflow_o`, gives a one-cycle `abort_o` pulse and ends the transfer (`busy_o` low).
- R7: While `sts_uflow_o` is set, every read-address strobe is refused and changes neither `sts_rdreq_o` nor `sts_dnr_o`.
- R8: In I3C mode, `sts_uflow_o` clears only after both a `getstatus_i` pulse and a `resume_i` pulse have been seen during the underflow, in either order. It goes low by the second clock edge after the later of the two pulses. A resume alone leaves it set.
- R9: In I2C mode, an underflow sets `sts_uflow_o` without an abort, and the transfer continues to its byte count. A `resume_i` pulse alone then clears the underflow.
- R10: `refill_o` is high exactly when the number of empty FIFO locations (DEPTH minus the level) is at least `empty_thld_i`.
- R11: A read-address strobe while busy is ignored: no ack, no nack, and the transfer goes on.
- R12: `irq_o` is high whenever any of the three status bits is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | A transmit command is queued |
| cmd_len_i | input | LEN_W | Byte count of the queued command |
| fifo_level_i | input | LVL_W | Bytes held in the transmit FIFO |
| start_thld_i | input | LVL_W | Minimum level that allows an accept |
| empty_thld_i | input | LVL_W | Free-location count that triggers a refill |
| rsp_full_i | input | 1 | Response queue is full |
| rd_addr_i | input | 1 | Private read address seen on the bus |
| pop_i | input | 1 | Bus side takes one transmit byte |
| getstatus_i | input | 1 | GETSTATUS read finished |
| resume_i | input | 1 | Software resume pulse |
| i2c_mode_i | input | 1 | 1 selects I2C mode |
| sts_clr_i | input | 2 | Write-one-to-clear: bit 0 clears read-request, bit 1 clears data-not-ready |
| ack_o | output | 1 | Read accepted (pulse) |
| nack_o | output | 1 | Read refused (pulse) |
| busy_o | output | 1 | Accepted transfer in progress |
| done_o | output | 1 | Last byte sent (pulse) |
| abort_o | output | 1 | Terminate transfer on bus (pulse) |
| sts_rdreq_o | output | 1 | Read refused with no command |
| sts_dnr_o | output | 1 | Data not ready |
| sts_uflow_o | output | 1 | Underflow error |
| irq_o | output | 1 | Any status set |
| refill_o | output | 1 | FIFO refill request |

## Verification
Reads are tried against five setups, each of which should lead to a different outcome:
- the FIFO holding exactly the command length;
- the FIFO holding only the start threshold;
- a short FIFO;
- a full response queue;
- a missing command.

Together they show which of the two data conditions allows an accept, and which refusal sets which status bit. Underflows are forced in both bus modes. In I3C mode this shows abort against no abort. It also shows how a transfer that ends early differs from one that runs to its count. Recovery is driven with the resume pulse first and then GETSTATUS, which exposes a design that clears on resume alone. In I2C mode a resume alone is driven, which exposes a design that always waits for GETSTATUS. The refill request is probed one level either side of its threshold, and a strobe is issued while a transfer is busy.

// File: rtl/i3c_rd_admit.sv
module i3c_rd_admit #(
  parameter int LEN_W = 8,
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic [LVL_W-1:0] start_thld_i,
  input  logic [LVL_W-1:0] empty_thld_i,
  input  logic             rsp_full_i,
  input  logic             rd_addr_i,
  input  logic             pop_i,
  input  logic             getstatus_i,
  input  logic             resume_i,
  input  logic             i2c_mode_i,
  input  logic [1:0]       sts_clr_i,
  output logic             ack_o,
  output logic             nack_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             abort_o,
  output logic             sts_rdreq_o,
  output logic             sts_dnr_o,
  output logic             sts_uflow_o,
  output logic             irq_o,
  output logic             refill_o
);

  localparam int CW = (LEN_W > LVL_W) ? LEN_W : LVL_W;

  logic [LEN_W-1:0] cnt_q;
  logic             ack_q, nack_q, done_q, abort_q;
  logic             rdreq_q, dnr_q, uflow_q;
  logic             gs_q, res_q;

  logic [CW-1:0] lvl_x, len_x;
  logic          take, data_ok, grant, refuse, underrun, hard_stop, recover;

  assign lvl_x     = CW'(fifo_level_i);
  assign len_x     = CW'(cmd_len_i);
  assign busy_o    = (cnt_q != '0);
  assign take      = rd_addr_i & ~busy_o;
  assign data_ok   = (lvl_x >= len_x) | (fifo_level_i >= start_thld_i);
  assign grant     = cmd_valid_i & data_ok & ~rsp_full_i & ~uflow_q;
  assign refuse    = take & ~grant;
  assign underrun  = pop_i & busy_o & (fifo_level_i == '0);
  assign hard_stop = underrun & ~i2c_mode_i;
  assign recover   = uflow_q & res_q & (gs_q | i2c_mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      nack_q  <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      ack_q   <= take & grant;
      nack_q  <= refuse;
      abort_q <= hard_stop;
      done_q  <= pop_i & busy_o & (cnt_q == LEN_W'(1)) & ~hard_stop;
      if (take && grant)
        cnt_q <= cmd_len_i;
      else if (pop_i && busy_o)
        cnt_q <= hard_stop ? '0 : cnt_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdreq_q <= 1'b0;
      dnr_q   <= 1'b0;
    end else begin
      if (refuse && !uflow_q && !cmd_valid_i) rdreq_q <= 1'b1;
      else if (sts_clr_i[0])                  rdreq_q <= 1'b0;
      if (refuse && !uflow_q && cmd_valid_i)  dnr_q <= 1'b1;
      else if (sts_clr_i[1])                  dnr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uflow_q <= 1'b0;
      gs_q    <= 1'b0;
      res_q   <= 1'b0;
    end else begin
      if (underrun)     uflow_q <= 1'b1;
      else if (recover) uflow_q <= 1'b0;
      if (recover || underrun)        gs_q <= 1'b0;
      else if (uflow_q && getstatus_i) gs_q <= 1'b1;
      if (recover || underrun)        res_q <= 1'b0;
      else if (uflow_q && resume_i)   res_q <= 1'b1;
    end
  end

  assign ack_o       = ack_q;
  assign nack_o      = nack_q;
  assign done_o      = done_q;
  assign abort_o     = abort_q;
  assign sts_rdreq_o = rdreq_q;
  assign sts_dnr_o   = dnr_q;
  assign sts_uflow_o = uflow_q;
  assign irq_o       = rdreq_q | dnr_q | uflow_q;
  assign refill_o    = (LVL_W'(DEPTH) - fifo_level_i) >= empty_thld_i;

endmodule

module i3c_rd_admit_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_addr_i,
  input logic             cmd_valid_i,
  input logic             rsp_full_i,
  input logic             pop_i,
  input logic [LVL_W-1:0] fifo_level_i,
  input logic             i2c_mode_i,
  input logic             ack_o,
  input logic             nack_o,
  input logic             busy_o,
  input logic             abort_o,
  input logic             sts_uflow_o,
  input logic             res_q
);

  a_r1_ack_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(rd_addr_i && cmd_valid_i && !rsp_full_i));

  a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && nack_o));

  a_r6_uflow_from_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_uflow_o) |-> $past(pop_i && fifo_level_i == '0));

  a_r7_no_ack_in_uflow: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_uflow_o && rd_addr_i) |=> !ack_o);

  a_r8_clear_needs_resume: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_uflow_o) |-> $past(res_q));

  a_r9_no_abort_in_i2c: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !$past(i2c_mode_i));

  a_r11_busy_ignores_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && rd_addr_i) |=> !(ack_o || nack_o));

endmodule

bind i3c_rd_admit i3c_rd_admit_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr_i(rd_addr_i), .cmd_valid_i(cmd_valid_i),
  .rsp_full_i(rsp_full_i), .pop_i(pop_i), .fifo_level_i(fifo_level_i),
  .i2c_mode_i(i2c_mode_i), .ack_o(ack_o), .nack_o(nack_o), .busy_o(busy_o),
  .abort_o(abort_o), .sts_uflow_o(sts_uflow_o), .res_q(res_q)
);

// File: tb/tb_i3c_rd_admit.sv
module tb_i3c_rd_admit;
  localparam int LEN_W = 8;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid_i = 0, rsp_full_i = 0, rd_addr_i = 0, pop_i = 0;
  logic getstatus_i = 0, resume_i = 0, i2c_mode_i = 0;
  logic [LEN_W-1:0] cmd_len_i = '0;
  logic [LVL_W-1:0] fifo_level_i = '0, start_thld_i = 5'd8, empty_thld_i = 5'd4;
  logic [1:0] sts_clr_i = '0;
  logic ack_o, nack_o, busy_o, done_o, abort_o;
  logic sts_rdreq_o, sts_dnr_o, sts_uflow_o, irq_o, refill_o;

  int checks = 0, errors = 0;
  bit exp_q[$];

  always #10 clk = ~clk;

  i3c_rd_admit #(.LEN_W(LEN_W), .DEPTH(DEPTH)) dut (.*);

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (ack_o || nack_o)) begin
      if (exp_q.size() == 0) chk("R11 unexpected decision", 1, 0);
      else chk("R1 decision ack", int'(ack_o), int'(exp_q.pop_front()));
    end
  end

  task automatic rd(bit exp_ack);
    @(negedge clk) rd_addr_i = 1; exp_q.push_back(exp_ack);
    @(negedge clk) rd_addr_i = 0;
  endtask

  task automatic pop(int lvl);
    @(negedge clk) pop_i = 1; fifo_level_i = LVL_W'(lvl);
    @(negedge clk) pop_i = 0;
  endtask

  task automatic clr(logic [1:0] v);
    @(negedge clk) sts_clr_i = v;
    @(negedge clk) sts_clr_i = '0;
  endtask

  task automatic pulse_gs();
    @(negedge clk) getstatus_i = 1;
    @(negedge clk) getstatus_i = 0;
  endtask

  task automatic pulse_res();
    @(negedge clk) resume_i = 1;
    @(negedge clk) resume_i = 0;
  endtask

  initial begin
    #(20 * 100000);
    chk("watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset ack R1", int'(ack_o), 0);
    chk("reset busy R5", int'(busy_o), 0);
    chk("reset status R12", int'(irq_o), 0);

    // R1 full length present, R5 count to done
    cmd_valid_i = 1; cmd_len_i = 4; fifo_level_i = 4;
    rd(1);
    chk("R5 busy after ack", int'(busy_o), 1);
    for (int i = 0; i < 3; i++) begin
      pop(4);
      chk("R5 no early done", int'(done_o), 0);
    end
    pop(4);
    chk("R5 done pulse", int'(done_o), 1);
    chk("R5 idle after done", int'(busy_o), 0);

    // R1 start threshold only, R6 underflow in I3C
    cmd_len_i = 10; fifo_level_i = 3; start_thld_i = 3;
    rd(1);
    pop(3);
    pop(0);
    chk("R6 uflow set", int'(sts_uflow_o), 1);
    chk("R6 abort pulse", int'(abort_o), 1);
    chk("R6 transfer ended", int'(busy_o), 0);
    chk("R12 irq on uflow", int'(irq_o), 1);
    @(negedge clk);
    chk("R6 abort one cycle", int'(abort_o), 0);

    // R7 refused during underflow, R4 clr cannot touch uflow
    fifo_level_i = 16;
    rd(0);
    chk("R7 no rdreq", int'(sts_rdreq_o), 0);
    chk("R7 no dnr", int'(sts_dnr_o), 0);
    clr(2'b11);
    chk("R4 uflow kept", int'(sts_uflow_o), 1);

    // R8 resume first, then GETSTATUS
    pulse_res();
    repeat (3) @(negedge clk);
    chk("R8 resume alone", int'(sts_uflow_o), 1);
    pulse_gs();
    @(negedge clk);
    chk("R8 cleared", int'(sts_uflow_o), 0);
    cmd_len_i = 1;
    rd(1);
    pop(16);
    chk("R8 transfer after recovery", int'(done_o), 1);

    // R2 no command
    cmd_valid_i = 0;
    rd(0);
    chk("R2 rdreq set", int'(sts_rdreq_o), 1);
    chk("R2 dnr clear", int'(sts_dnr_o), 0);
    chk("R12 irq", int'(irq_o), 1);
    clr(2'b01);
    chk("R4 rdreq cleared", int'(sts_rdreq_o), 0);
    chk("R12 irq low", int'(irq_o), 0);

    // R3 short data, then full response queue
    cmd_valid_i = 1; cmd_len_i = 8; fifo_level_i = 2; start_thld_i = 4;
    rd(0);
    chk("R3 dnr on short data", int'(sts_dnr_o), 1);
    rd(0);
    chk("R3 rdreq untouched", int'(sts_rdreq_o), 0);
    clr(2'b10);
    chk("R4 dnr cleared", int'(sts_dnr_o), 0);
    fifo_level_i = 16; rsp_full_i = 1;
    rd(0);
    chk("R3 dnr on rsp full", int'(sts_dnr_o), 1);
    rsp_full_i = 0;
    clr(2'b10);

    // R9 I2C underflow
    i2c_mode_i = 1; cmd_len_i = 3;
    rd(1);
    pop(0);
    chk("R9 uflow set", int'(sts_uflow_o), 1);
    chk("R9 no abort", int'(abort_o), 0);
    chk("R9 still busy", int'(busy_o), 1);
    pop(16);
    pop(16);
    chk("R9 runs to count", int'(done_o), 1);
    rd(0);
    pulse_res();
    @(negedge clk);
    chk("R9 resume alone clears", int'(sts_uflow_o), 0);
    i2c_mode_i = 0;

    // R10 refill threshold
    empty_thld_i = 4;
    @(negedge clk) fifo_level_i = 12; #1;
    chk("R10 refill at threshold", int'(refill_o), 1);
    @(negedge clk) fifo_level_i = 13; #1;
    chk("R10 no refill above", int'(refill_o), 0);

    // R11 strobe while busy
    fifo_level_i = 16; cmd_len_i = 2;
    rd(1);
    @(negedge clk) rd_addr_i = 1;
    @(negedge clk) rd_addr_i = 0;
    chk("R11 no ack while busy", int'(ack_o), 0);
    chk("R11 no nack while busy", int'(nack_o), 0);
    chk("R11 still busy", int'(busy_o), 1);
    pop(16);
    pop(16);
    chk("R11 transfer completes", int'(done_o), 1);

    repeat (3) @(negedge clk);
    chk("R1 all decisions seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule